// File: doc/BRIEF.md
# Fused Multiply-Add NaN Resolver

This unit sits beside a single-precision fused multiply-add datapath that computes a*b+c. It checks the three 32-bit operands for special cases. It decides whether the datapath result must be replaced, and with which value. It also raises the invalid-operation flag. The multiply-add arithmetic, rounding and all other exception flags stay in the datapath.

A mode input selects between two NaN conventions:

- **Legacy convention.** A fraction MSB of 1 marks a signalling NaN. Every NaN result is replaced by the legacy default NaN.
- **2008 convention.** A fraction MSB of 1 marks a quiet NaN. A chosen NaN operand is returned with its fraction MSB set.

The two conventions also differ in three further ways:

- the order in which NaN operands are ranked;
- the default NaN pattern;
- the outcome of infinity times zero when c is a NaN.

The inputs are sampled on each rising clock edge. The decision appears on the registered outputs one cycle later. There is no handshake. The unit has no state machine: it is a single register stage placed after combinational decode and selection logic.

Top module: `fma_nan_resolver`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `nan_override`, `invalid_op`, `nan_src` and `result` are all zero.
- R2: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is non-zero. The NaN is signalling in these cases: in legacy mode (`mode_2008`=0) when bit 22 is 1, and in 2008 mode (`mode_2008`=1) when bit 22 is 0.
- R3: `nan_override` is 1 exactly when the operand set contains at least one NaN, or when the product is infinity times zero. When `nan_override` is 0, `result` and `nan_src` are 0.
- R4: `invalid_op` is 1 exactly when an operand is a signalling NaN, or when the product is infinity times zero (a infinite and b zero, or a zero and b infinite; zero and infinity of either sign).
- R5: In legacy mode, every overriding result is the default NaN 0x7FBFFFFF.
- R6: In 2008 mode, a propagated NaN is the chosen operand with bit 22 forced to 1. Its sign and all other bits are kept. The 2008 default NaN is 0x7FC00000.
- R7: Signalling NaNs win over quiet NaNs. In 2008 mode the operands are ranked c, then a, then b, within each class. `nan_src` reports the winner: 1 for a, 2 for b, 3 for c, and 0 when no operand is the source.
- R8: In legacy mode the ranking within each class is a, then b, then c, as reported by `nan_src`.
- R9: For infinity times zero with c a NaN, `nan_src` is 3 in both modes. The result is 0x7FBFFFFF in legacy mode. In 2008 mode the result is c with bit 22 set.
- R10: For infinity times zero with c not a NaN, `nan_src` is 0 and the result is the default NaN of the current mode.
- R11: The outputs reflect the inputs sampled at the previous rising edge (one cycle of latency). A new operand set can be applied every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_2008 | input | 1 | 1 selects the 2008 NaN convention, 0 the legacy one |
| op_a | input | 32 | Multiplicand a |
| op_b | input | 32 | Multiplier b |
| op_c | input | 32 | Addend c |
| nan_override | output | 1 | Result must replace the datapath value |
| invalid_op | output | 1 | Invalid-operation flag |
| nan_src | output | 2 | Operand that supplied or triggered the result (0 none, 1 a, 2 b, 3 c) |
| result | output | 32 | Replacement value; zero when no override |

## Verification
The assertions check a set of properties on every cycle:

- an idle output stays zero;
- `invalid_op` never rises without an override;
- a reported source always implies an override;
- every legacy override carries 0x7FBFFFFF;
- every 2008 override is a quiet NaN;
- a source of 0 always comes with the default NaN of the mode used one cycle earlier.

Some behaviours can only be shown by the bench scenarios, because the bench holds a model of the requirements:

- which NaN class is recognised in each mode;
- the ranking c,a,b against a,b,c;
- payload and sign preservation when quietening;
- the distinction between the two infinity-times-zero outcomes.

To exercise these, the bench sweeps every quiet, signalling and ordinary combination of the three operands in both modes. It also runs each infinity-times-zero arrangement.

// File: rtl/fmanr_pkg.sv
package fmanr_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int NUM_OPS = 3;
    localparam int QBIT   = FRAC_W - 1;

    localparam logic [WORD_W-1:0] DNAN_LEGACY = 32'h7FBF_FFFF;
    localparam logic [WORD_W-1:0] DNAN_2008   = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_A    = 2'd1,
        SRC_B    = 2'd2,
        SRC_C    = 2'd3
    } src_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } op_class_t;

endpackage

// File: rtl/fmanr_classify.sv
module fmanr_classify
    import fmanr_pkg::*;
(
    input  logic [WORD_W-1:0] operand,
    input  logic              mode_2008,
    output op_class_t         cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;

    assign exp_f     = operand[WORD_W-2 -: EXP_W];
    assign frac_f    = operand[FRAC_W-1:0];
    assign exp_ones  = &exp_f;
    assign exp_zero  = ~|exp_f;
    assign frac_zero = ~|frac_f;

    always_comb begin
        cls.is_nan  = exp_ones & ~frac_zero;
        // legacy: quiet bit set means signalling; 2008: clear means signalling
        cls.is_snan = cls.is_nan & (frac_f[QBIT] ^ mode_2008);
        cls.is_inf  = exp_ones & frac_zero;
        cls.is_zero = exp_zero & frac_zero;
    end
endmodule

// File: rtl/fmanr_pick.sv
module fmanr_pick
    import fmanr_pkg::*;
(
    input  logic [NUM_OPS-1:0] nan_vec,
    input  logic [NUM_OPS-1:0] snan_vec,
    input  logic               mode_2008,
    output logic [1:0]         winner
);
    // ranking tables: index of operand checked at each step
    localparam logic [1:0] ORD_LEG [NUM_OPS] = '{2'd0, 2'd1, 2'd2};
    localparam logic [1:0] ORD_NEW [NUM_OPS] = '{2'd2, 2'd0, 2'd1};

    logic       found_s;
    logic       found_q;
    logic [1:0] pick_s;
    logic [1:0] pick_q;

    always_comb begin
        found_s = 1'b0;
        found_q = 1'b0;
        pick_s  = 2'd0;
        pick_q  = 2'd0;
        for (int k = 0; k < NUM_OPS; k++) begin
            logic [1:0] idx;
            idx = mode_2008 ? ORD_NEW[k] : ORD_LEG[k];
            if (!found_s && snan_vec[idx]) begin
                found_s = 1'b1;
                pick_s  = idx;
            end
            if (!found_q && nan_vec[idx]) begin
                found_q = 1'b1;
                pick_q  = idx;
            end
        end
        unique case ({found_s, found_q})
            2'b11, 2'b10: winner = 2'd1 + pick_s;
            2'b01:        winner = 2'd1 + pick_q;
            default:      winner = 2'd0;
        endcase
    end
endmodule

// File: rtl/fma_nan_resolver.sv
module fma_nan_resolver
    import fmanr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_2008,
    input  logic [31:0]       op_a,
    input  logic [31:0]       op_b,
    input  logic [31:0]       op_c,
    output logic              nan_override,
    output logic              invalid_op,
    output logic [1:0]        nan_src,
    output logic [31:0]       result
);
    logic [WORD_W-1:0]  ops [NUM_OPS];
    op_class_t          cls [NUM_OPS];
    logic [NUM_OPS-1:0] nan_vec;
    logic [NUM_OPS-1:0] snan_vec;
    logic [1:0]         winner;
    logic               inf_zero;
    logic [WORD_W-1:0]  dnan;
    logic [WORD_W-1:0]  chosen;

    logic               ovr_d;
    logic               inv_d;
    logic [1:0]         src_d;
    logic [WORD_W-1:0]  res_d;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
        fmanr_classify u_cls (
            .operand   (ops[i]),
            .mode_2008 (mode_2008),
            .cls       (cls[i])
        );
        assign nan_vec[i]  = cls[i].is_nan;
        assign snan_vec[i] = cls[i].is_snan;
    end

    fmanr_pick u_pick (
        .nan_vec   (nan_vec),
        .snan_vec  (snan_vec),
        .mode_2008 (mode_2008),
        .winner    (winner)
    );

    assign inf_zero = (cls[0].is_inf & cls[1].is_zero) |
                      (cls[0].is_zero & cls[1].is_inf);
    assign dnan     = mode_2008 ? DNAN_2008 : DNAN_LEGACY;

    always_comb begin
        unique case (winner)
            2'd1:    chosen = op_a;
            2'd2:    chosen = op_b;
            default: chosen = op_c;
        endcase
    end

    always_comb begin
        ovr_d = 1'b0;
        inv_d = 1'b0;
        src_d = SRC_NONE;
        res_d = '0;
        if (inf_zero) begin
            ovr_d = 1'b1;
            inv_d = 1'b1;
            if (nan_vec[2]) begin
                src_d = SRC_C;
                res_d = mode_2008 ? (op_c | (WORD_W'(1) << QBIT)) : dnan;
            end else begin
                res_d = dnan;
            end
        end else if (|nan_vec) begin
            ovr_d = 1'b1;
            inv_d = |snan_vec;
            src_d = winner;
            res_d = mode_2008 ? (chosen | (WORD_W'(1) << QBIT)) : dnan;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nan_override <= 1'b0;
            invalid_op   <= 1'b0;
            nan_src      <= SRC_NONE;
            result       <= '0;
        end else begin
            nan_override <= ovr_d;
            invalid_op   <= inv_d;
            nan_src      <= src_d;
            result       <= res_d;
        end
    end
endmodule

// File: rtl/fmanr_checker.sv
module fmanr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_2008,
    input logic        nan_override,
    input logic        invalid_op,
    input logic [1:0]  nan_src,
    input logic [31:0] result
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !nan_override |-> (result == 32'h0 && nan_src == 2'd0)); // R3

    AST_INVALID_NEEDS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_op |-> nan_override); // R4

    AST_SRC_NEEDS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (nan_src != 2'd0) |-> nan_override); // R7

    AST_LEGACY_DNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && nan_override && !$past(mode_2008)) |-> (result == 32'h7FBF_FFFF)); // R5

    AST_2008_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && nan_override && $past(mode_2008)) |->
            (result[30:23] == 8'hFF && result[22])); // R6

    AST_NOSRC_DNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && nan_override && nan_src == 2'd0) |->
            (result == ($past(mode_2008) ? 32'h7FC0_0000 : 32'h7FBF_FFFF))); // R10
endmodule

bind fma_nan_resolver fmanr_checker u_fmanr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_2008    (mode_2008),
    .nan_override (nan_override),
    .invalid_op   (invalid_op),
    .nan_src      (nan_src),
    .result       (result)
);

// File: tb/fma_nan_resolver_bench.sv
module fma_nan_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_2008 = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] op_c = '0;
    logic        nan_override;
    logic        invalid_op;
    logic [1:0]  nan_src;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    fma_nan_resolver u_fma_nan_resolver (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_2008    (mode_2008),
        .op_a         (op_a),
        .op_b         (op_b),
        .op_c         (op_c),
        .nan_override (nan_override),
        .invalid_op   (invalid_op),
        .nan_src      (nan_src),
        .result       (result)
    );

    // kinds: 0 ordinary number, 1 quiet NaN, 2 signalling NaN
    function automatic logic [31:0] mk(input int kind, input bit m08,
                                       input bit sgn, input logic [7:0] pay);
        logic [31:0] v;
        case (kind)
            1: v = {sgn, 8'hFF, m08, 14'd0, pay};
            2: v = {sgn, 8'hFF, ~m08, 14'd0, pay};
            default: v = {sgn, 8'h40, 15'd0, pay};
        endcase
        return v;
    endfunction

    task automatic check(input string req, input logic [66:0] act, input logic [66:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual ovr=%0b inv=%0b src=%0d res=%h expected ovr=%0b inv=%0b src=%0d res=%h",
                     req, act[66], act[65], act[64:63], act[31:0],
                     exp[66], exp[65], exp[64:63], exp[31:0]);
        end
    endtask

    function automatic logic [66:0] pack(input bit o, input bit i, input logic [1:0] s,
                                         input logic [31:0] r);
        return {o, i, s, 31'd0, r};
    endfunction

    task automatic apply(input bit m08, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c);
        @(negedge clk);
        mode_2008 = m08; op_a = a; op_b = b; op_c = c;
        @(negedge clk); // R11: one rising edge later
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        mode_2008 = 1'b1;
        op_a = 32'h7F80_0001;
        op_b = 32'h0;
        op_c = 32'h0;
        repeat (3) @(negedge clk);
        check("R1 during reset", pack(nan_override, invalid_op, nan_src, result), '0);
        rst_n = 1'b1;
        op_a = 32'h3F80_0000;
        @(negedge clk);
        check("R1 after release", pack(nan_override, invalid_op, nan_src, result), '0);
    endtask

    // sweep of every number/quiet/signalling combination in one mode
    task automatic t_sweep(input bit m08);
        for (int ka = 0; ka < 3; ka++)
        for (int kb = 0; kb < 3; kb++)
        for (int kc = 0; kc < 3; kc++) begin
            int kinds [3];
            logic [31:0] v [3];
            int ord [3];
            int win;
            bit any_n, any_s;
            logic [31:0] er;
            string tag;
            kinds[0] = ka; kinds[1] = kb; kinds[2] = kc;
            v[0] = mk(ka, m08, 1'b0, 8'h11);
            v[1] = mk(kb, m08, 1'b1, 8'h22);
            v[2] = mk(kc, m08, 1'b0, 8'h33);
            if (m08) begin ord[0] = 2; ord[1] = 0; ord[2] = 1; end
            else     begin ord[0] = 0; ord[1] = 1; ord[2] = 2; end
            win = -1;
            for (int k = 0; k < 3; k++)
                if (win < 0 && kinds[ord[k]] == 2) win = ord[k];
            for (int k = 0; k < 3; k++)
                if (win < 0 && kinds[ord[k]] == 1) win = ord[k];
            any_n = (ka != 0) || (kb != 0) || (kc != 0);
            any_s = (ka == 2) || (kb == 2) || (kc == 2);
            if (!any_n) er = 32'h0;
            else if (!m08) er = 32'h7FBF_FFFF;
            else er = v[win] | 32'h0040_0000;
            tag = m08 ? "R2 R3 R4 R6 R7 sweep" : "R2 R3 R4 R5 R8 sweep";
            apply(m08, v[0], v[1], v[2]);
            check(tag, pack(nan_override, invalid_op, nan_src, result),
                  pack(any_n, any_s, any_n ? 2'(win + 1) : 2'd0, er));
        end
    endtask

    task automatic t_inf_zero(input bit m08);
        logic [31:0] pinf = 32'h7F80_0000;
        logic [31:0] ninf = 32'hFF80_0000;
        logic [31:0] nzer = 32'h8000_0000;
        logic [31:0] dn   = m08 ? 32'h7FC0_0000 : 32'h7FBF_FFFF;
        logic [31:0] cq   = mk(1, m08, 1'b1, 8'h5A);
        logic [31:0] cs   = mk(2, m08, 1'b0, 8'h6B);
        apply(m08, pinf, 32'h0, 32'h3F80_0000);
        check("R10 R4 inf*0+num", pack(nan_override, invalid_op, nan_src, result),
              pack(1'b1, 1'b1, 2'd0, dn));
        apply(m08, nzer, ninf, 32'h0);
        check("R10 R4 0*-inf+0", pack(nan_override, invalid_op, nan_src, result),
              pack(1'b1, 1'b1, 2'd0, dn));
        apply(m08, pinf, 32'h0, cq);
        check("R9 inf*0+qnan", pack(nan_override, invalid_op, nan_src, result),
              pack(1'b1, 1'b1, 2'd3, m08 ? (cq | 32'h0040_0000) : dn));
        apply(m08, 32'h0, ninf, cs);
        check("R9 0*inf+snan", pack(nan_override, invalid_op, nan_src, result),
              pack(1'b1, 1'b1, 2'd3, m08 ? (cs | 32'h0040_0000) : dn));
        apply(m08, pinf, 32'h3F80_0000, cq);
        check("R7 inf*1+qnan not inf*0", pack(nan_override, invalid_op, nan_src, result),
              pack(1'b1, 1'b0, 2'd3, m08 ? cq : dn));
        apply(m08, pinf, pinf, 32'h3F80_0000);
        check("R3 inf*inf no override", pack(nan_override, invalid_op, nan_src, result),
              pack(1'b0, 1'b0, 2'd0, 32'h0));
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        mode_2008 = 1'b1; op_a = 32'h7F80_0000; op_b = 32'h0; op_c = 32'h0;
        @(negedge clk);
        check("R11 first of pair", pack(nan_override, invalid_op, nan_src, result),
              pack(1'b1, 1'b1, 2'd0, 32'h7FC0_0000));
        mode_2008 = 1'b0; op_a = 32'h3F80_0000; op_b = 32'h3F80_0000; op_c = 32'h0;
        @(negedge clk);
        check("R11 second of pair", pack(nan_override, invalid_op, nan_src, result),
              pack(1'b0, 1'b0, 2'd0, 32'h0));
    endtask

    initial begin
        t_reset();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_inf_zero(1'b0);
        t_inf_zero(1'b1);
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule